// File: doc/BRIEF.md
# Two-Share Masked Chi Row

This block evaluates the nonlinear chi map on one 5-bit row of a Keccak state. The row is held as two Boolean shares, `a_in` and `b_in`, and the row value is their XOR. The result also leaves as two shares, `a_out` and `b_out`. Each of the five AND terms is a first-order domain-oriented masked AND. The inversion sits in domain A only, and the XOR network is copied into each domain. A register separates the cross-domain products from the point where they merge into a domain.

The parameter `REUSE_X` sets where the cross-domain masks come from. When it is 0, `z_in` supplies five fresh random bits per evaluation. When it is 1, the shares of the row's own linear bit x_i mask the cross products in place of the random bits. That bit then reaches each output share exactly once, so the unmasked result does not change and `z_in` has no effect.

The parameter `DOUBLE_CLK` selects the timing variant. When it is 0, the block is pipelined: the inner-domain and cross-domain terms are both registered on the rising edge, and the result appears one cycle after the inputs. When it is 1, there are no inner-domain registers, and the cross-domain registers capture on the falling edge. The result for the inputs of a cycle is then valid in the second half of that same cycle.

Top module: `masked_chi_row`

## Requirements
- R1: Bit i of `a_out ^ b_out` equals x[i] ^ (~x[(i+1) mod 5] & x[(i+2) mod 5]), where x is `a_in ^ b_in` for the evaluated inputs. This holds for every share split, every `z_in` and both settings of each parameter.
- R2: With `DOUBLE_CLK`=0, the outputs after a rising edge reflect the inputs sampled at that edge, so the latency is one cycle.
- R3: With `DOUBLE_CLK`=1, the outputs reflect the current cycle's inputs once the falling edge of that cycle has passed. The inputs must stay stable from the rising edge through the falling edge.
- R4: With `REUSE_X`=1, changing `z_in` while `a_in` and `b_in` are held changes neither output share.
- R5: With `REUSE_X`=0, flipping bit i of `z_in` while `a_in` and `b_in` are held flips bit i of both `a_out` and `b_out` and no other bit.
- R6: An active-low `rst_n` asynchronously clears every register. With `DOUBLE_CLK`=0, both output shares read zero while reset is asserted, whatever the inputs.
- R7: If `b_in` is zero and `z_in` is zero, `b_out` is zero and `a_out` equals chi of `a_in` in every configuration. This is because the inversion lives only in domain A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The pipelined variant uses the rising edge; the double-clocked variant's cross registers use the falling edge. |
| rst_n | input | 1 | Asynchronous active-low reset. |
| a_in | input | 5 | Row share in domain A. |
| b_in | input | 5 | Row share in domain B. |
| z_in | input | 5 | Fresh mask bits, one per output bit. Ignored when `REUSE_X`=1. |
| a_out | output | 5 | Result share in domain A. |
| b_out | output | 5 | Result share in domain B. |

## Verification
The assertions assume a few things about the inputs. First, the inputs change only just after a rising edge, so the double-clocked variant always registers a settled value on the falling edge. Second, reset is released away from any clock edge. Third, the `z_in` bits are meant to be independent of the shares, although correctness does not depend on this. The stimulus applies every input a moment after the rising edge and samples one unit before the next rising edge. It draws the share splits and mask bits at random, sweeps all 32 row values several times, and holds the shares still whenever it probes the role of `z_in`.

// File: rtl/masked_chi_row.sv
module masked_chi_row #(
  parameter bit REUSE_X    = 1'b0,
  parameter bit DOUBLE_CLK = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] a_in,
  input  logic [4:0] b_in,
  input  logic [4:0] z_in,
  output logic [4:0] a_out,
  output logic [4:0] b_out
);
  localparam int ROW = 5;

  logic [ROW-1:0] a_nx, b_nx, a_cc, b_cc;
  logic [ROW-1:0] mask_a, mask_b, lin_a, lin_b;
  logic [ROW-1:0] cross_a_d, cross_b_d, inner_a_d, inner_b_d;
  logic [ROW-1:0] cross_a_q, cross_b_q;

  for (genvar i = 0; i < ROW; i++) begin : g_taps
    localparam int J1 = (i + 1) % ROW;
    localparam int J2 = (i + 2) % ROW;
    assign a_nx[i] = ~a_in[J1];
    assign b_nx[i] =  b_in[J1];
    assign a_cc[i] =  a_in[J2];
    assign b_cc[i] =  b_in[J2];
  end

  assign mask_a = REUSE_X ? a_in : z_in;
  assign mask_b = REUSE_X ? b_in : z_in;
  assign lin_a  = REUSE_X ? '0   : a_in;
  assign lin_b  = REUSE_X ? '0   : b_in;

  assign cross_a_d = (a_nx & b_cc) ^ mask_a;
  assign cross_b_d = (b_nx & a_cc) ^ mask_b;
  assign inner_a_d = (a_nx & a_cc) ^ lin_a;
  assign inner_b_d = (b_nx & b_cc) ^ lin_b;

  if (DOUBLE_CLK) begin : g_dbl
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cross_a_q <= '0;
        cross_b_q <= '0;
      end else begin
        cross_a_q <= cross_a_d;
        cross_b_q <= cross_b_d;
      end
    end
    assign a_out = inner_a_d ^ cross_a_q;
    assign b_out = inner_b_d ^ cross_b_q;
  end else begin : g_pipe
    logic [ROW-1:0] inner_a_q, inner_b_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cross_a_q <= '0;
        cross_b_q <= '0;
        inner_a_q <= '0;
        inner_b_q <= '0;
      end else begin
        cross_a_q <= cross_a_d;
        cross_b_q <= cross_b_d;
        inner_a_q <= inner_a_d;
        inner_b_q <= inner_b_d;
      end
    end
    assign a_out = inner_a_q ^ cross_a_q;
    assign b_out = inner_b_q ^ cross_b_q;
  end
endmodule

module masked_chi_row_chk #(
  parameter bit REUSE_X    = 1'b0,
  parameter bit DOUBLE_CLK = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] a_in,
  input logic [4:0] b_in,
  input logic [4:0] z_in,
  input logic [4:0] a_out,
  input logic [4:0] b_out
);
  function automatic logic [4:0] chi5(input logic [4:0] x);
    logic [4:0] y;
    for (int i = 0; i < 5; i++)
      y[i] = x[i] ^ (~x[(i + 1) % 5] & x[(i + 2) % 5]);
    return y;
  endfunction

  logic armed, armed2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      armed2 <= 1'b0;
    end else begin
      armed  <= 1'b1;
      armed2 <= armed;
    end
  end

  // R1, R2
  a_r2_pipe_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (!DOUBLE_CLK && armed) |=> ((a_out ^ b_out) == chi5($past(a_in ^ b_in))));

  // R1, R3
  a_r3_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (DOUBLE_CLK && armed) |-> ((a_out ^ b_out) == chi5(a_in ^ b_in)));

  a_r4_pipe_z_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (REUSE_X && !DOUBLE_CLK && armed && $stable(a_in) && $stable(b_in))
      |=> ($stable(a_out) && $stable(b_out)));

  a_r4_dbl_z_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (REUSE_X && DOUBLE_CLK && armed2 && $stable(a_in) && $stable(b_in))
      |-> ($stable(a_out) && $stable(b_out)));

  a_r5_z_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (!REUSE_X && !DOUBLE_CLK && armed2 && $stable(a_in) && $stable(b_in))
      |=> (((a_out ^ $past(a_out)) == ($past(z_in) ^ $past(z_in, 2))) &&
           ((b_out ^ $past(b_out)) == ($past(z_in) ^ $past(z_in, 2)))));

  always @(posedge clk) begin
    if (!rst_n && !DOUBLE_CLK)
      a_r6_reset_clear: assert (a_out == 5'd0 && b_out == 5'd0);
  end
endmodule

bind masked_chi_row masked_chi_row_chk #(
  .REUSE_X(REUSE_X), .DOUBLE_CLK(DOUBLE_CLK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .z_in(z_in),
  .a_out(a_out), .b_out(b_out)
);

// File: tb/tb_masked_chi_row.sv
module tb_masked_chi_row;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] a_in = '0, b_in = '0, z_in = '0;
  logic [4:0] ao [4];
  logic [4:0] bo [4];

  int n_chk = 0;
  int n_fail = 0;
  logic [4:0] exp_q [$];

  always #(PERIOD/2) clk = ~clk;

  // 0: pipelined fresh, 1: pipelined reuse, 2: double-clocked fresh, 3: double-clocked reuse
  masked_chi_row #(.REUSE_X(1'b0), .DOUBLE_CLK(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .z_in(z_in), .a_out(ao[0]), .b_out(bo[0]));
  masked_chi_row #(.REUSE_X(1'b1), .DOUBLE_CLK(1'b0)) dut_pr (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .z_in(z_in), .a_out(ao[1]), .b_out(bo[1]));
  masked_chi_row #(.REUSE_X(1'b0), .DOUBLE_CLK(1'b1)) dut_df (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .z_in(z_in), .a_out(ao[2]), .b_out(bo[2]));
  masked_chi_row #(.REUSE_X(1'b1), .DOUBLE_CLK(1'b1)) dut_dr (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .z_in(z_in), .a_out(ao[3]), .b_out(bo[3]));

  function automatic logic [4:0] ref_chi(input logic [4:0] x);
    logic [4:0] y;
    for (int i = 0; i < 5; i++) begin
      int n1 = (i + 1) % 5;
      int n2 = (i + 2) % 5;
      y[i] = x[i] ^ ((x[n1] ? 1'b0 : 1'b1) & x[n2]);
    end
    return y;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] a, input logic [4:0] b, input logic [4:0] z);
    logic [4:0] x;
    logic [4:0] e;
    @(posedge clk);
    #1;
    a_in = a; b_in = b; z_in = z;
    #(PERIOD - 2);
    x = a ^ b;
    exp_q.push_back(ref_chi(x));
    for (int k = 2; k < 4; k++)
      chk((ao[k] ^ bo[k]) == ref_chi(x), "R1 R3 same-cycle chi", ao[k] ^ bo[k], ref_chi(x));
    if (exp_q.size() > 1) begin
      e = exp_q.pop_front();
      for (int k = 0; k < 2; k++)
        chk((ao[k] ^ bo[k]) == e, "R1 R2 one-cycle chi", ao[k] ^ bo[k], e);
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [4:0] sa [4];
    logic [4:0] sb [4];
    logic [4:0] ra, rb, z1, z2;
    repeat (3) @(posedge clk);
    #2;
    for (int k = 0; k < 4; k++)
      chk(ao[k] == 0 && bo[k] == 0, "R6 reset state", {ao[k], bo[k]}, 0);
    @(posedge clk);
    #3 rst_n = 1'b1;

    for (int pass = 0; pass < 3; pass++)
      for (int v = 0; v < 32; v++) begin
        ra = 5'($urandom);
        step(ra, ra ^ 5'(v), 5'($urandom));
      end

    // R7: domain B stays zero when its share and the masks are zero
    for (int v = 0; v < 32; v += 7) begin
      step(5'(v), 5'd0, 5'd0);
      step(5'(v), 5'd0, 5'd0);
      for (int k = 0; k < 4; k++) begin
        chk(bo[k] == 0, "R7 b_out zero", bo[k], 0);
        chk(ao[k] == ref_chi(5'(v)), "R7 a_out chi", ao[k], ref_chi(5'(v)));
      end
    end

    // R4 and R5: hold the shares and vary z_in
    for (int t = 0; t < 10; t++) begin
      ra = 5'($urandom);
      rb = 5'($urandom);
      z1 = 5'($urandom);
      z2 = (t < 5) ? (z1 ^ (5'd1 << t)) : 5'($urandom);
      step(ra, rb, z1);
      step(ra, rb, z1);
      for (int k = 0; k < 4; k++) begin sa[k] = ao[k]; sb[k] = bo[k]; end
      step(ra, rb, z2);
      step(ra, rb, z2);
      for (int k = 1; k < 4; k += 2) begin
        chk(ao[k] == sa[k], "R4 a_out ignores z", ao[k], sa[k]);
        chk(bo[k] == sb[k], "R4 b_out ignores z", bo[k], sb[k]);
      end
      for (int k = 0; k < 4; k += 2) begin
        chk((ao[k] ^ sa[k]) == (z1 ^ z2), "R5 a_out follows z", ao[k] ^ sa[k], z1 ^ z2);
        chk((bo[k] ^ sb[k]) == (z1 ^ z2), "R5 b_out follows z", bo[k] ^ sb[k], z1 ^ z2);
      end
    end

    // R6: asynchronous reset in the middle of a cycle
    step(5'h1b, 5'h04, 5'h0f);
    @(posedge clk);
    #3 rst_n = 1'b0;
    #1;
    for (int k = 0; k < 2; k++)
      chk(ao[k] == 0 && bo[k] == 0, "R6 async clear", {ao[k], bo[k]}, 0);
    @(posedge clk);
    #2;
    for (int k = 0; k < 2; k++)
      chk(ao[k] == 0 && bo[k] == 0, "R6 held in reset", {ao[k], bo[k]}, 0);
    #1 rst_n = 1'b1;
    exp_q.delete();
    for (int v = 0; v < 32; v++) begin
      ra = 5'($urandom);
      step(ra, ra ^ 5'(31 - v), 5'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule